// File: doc/BRIEF.md
# Mode-0 Single-Byte SPI Master

This block is a full-duplex serial master that moves one word per request, eight bits by default. The serial clock idles low and runs at half the system clock rate. A caller raises `start` with the word to send on `tx_data`. The block takes that request on a clock edge only when it is idle. It then pulls `cs_n` low and shifts the word out on `mosi`, most significant bit first. At the same time it collects the word coming back on `miso`.

Outgoing data changes only while `sclk` is low. Incoming data is captured on each rising `sclk` edge. One system cycle after the last rising edge, the block releases the bus and raises `done` for a single cycle, with the received word on `rx_data`. A synchronous reset returns the block to idle on the edge where it is seen, even in the middle of a transfer.

Top module: `spi_byte_master`

## Requirements
- R1: While `rst` is high, after each clock edge the outputs read `busy`=0, `done`=0, `cs_n`=1 and `sclk`=0.
- R2: When `start` is high and `busy` is low at a clock edge, in the next cycle `busy`=1, `cs_n`=0, `sclk`=0, and `mosi` equals bit 7 (the top bit) of the `tx_data` seen at that edge.
- R3: During a transfer `sclk` inverts on every clock edge after acceptance, up to and including the edge of the 8th rising `sclk` edge, so one `sclk` period spans two clock cycles.
- R4: `mosi` presents the transmit word top bit first. It changes only on edges where `sclk` falls, and it holds its value across edges where `sclk` rises.
- R5: `miso` is captured on each rising `sclk` edge. The first captured bit lands in bit 7 of `rx_data` and the last in bit 0.
- R6: On the clock edge after the 8th rising `sclk` edge (16 cycles after acceptance), `busy` falls, `cs_n` rises and `sclk` returns low. In that cycle `done` is high for exactly one cycle and `rx_data` holds the received word.
- R7: A `start` pulse arriving while `busy` is high has no effect. No new transfer begins and the current one completes unchanged.
- R8: Changes on `tx_data` after acceptance do not alter the bits sent on `mosi`.
- R9: A request raised in the cycle where `done` is high is accepted on the next edge.
- R10: Raising `rst` mid-transfer aborts it on that edge. No `done` pulse follows for the aborted word.
- R11: Whenever `busy` is low, `cs_n` is high and `sclk` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request a transfer when idle |
| tx_data | input | DATA_W (8) | Word to transmit, top bit first |
| miso | input | 1 | Serial data from the slave |
| mosi | output | 1 | Serial data to the slave |
| sclk | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Chip select, active low |
| busy | output | 1 | High while a transfer runs |
| done | output | 1 | One-cycle pulse when `rx_data` is valid |
| rx_data | output | DATA_W (8) | Received word |

## Verification
The bench builds the block with its default word width of 8. At that width the full 16-cycle transfer can be traced edge by edge: each low phase of `sclk` is checked against the expected `mosi` bit, and a slave model feeds a known `miso` word. The 8-bit width also brings the all-zero and all-one words within reach, along with alternating words and back-to-back requests. Further runs inject a `start` and new `tx_data` mid-transfer, and one run aborts a transfer with a reset partway through.

// File: rtl/spi_m0_pkg.sv
package spi_m0_pkg;

  typedef enum logic {
    XS_IDLE = 1'b0,
    XS_RUN  = 1'b1
  } xfer_state_e;

endpackage

// File: rtl/spi_m0_sclk_gen.sv
module spi_m0_sclk_gen (
  input  logic clk,
  input  logic rst,
  input  logic running,
  input  logic park,
  output logic sclk,
  output logic rise_evt,
  output logic fall_evt
);

  logic sclk_q;

  // Next level of the serial clock: parked low, or inverted while running.
  function automatic logic next_level(input logic cur, input logic run_i,
                                      input logic park_i);
    if (park_i)
      return 1'b0;
    else if (run_i)
      return ~cur;
    else
      return 1'b0;
  endfunction

  always_ff @(posedge clk) begin
    if (rst)
      sclk_q <= 1'b0;
    else
      sclk_q <= next_level(sclk_q, running, park);
  end

  assign sclk     = sclk_q;
  assign rise_evt = running && !park && !sclk_q;
  assign fall_evt = running && !park && sclk_q;

  // R3: a running, unparked serial clock changes level on every edge
  a_r3_sclk_toggles: assert property (@(posedge clk) disable iff (rst)
    (running && !park) |=> (sclk_q != $past(sclk_q)));

endmodule

// File: rtl/spi_m0_edge_counter.sv
module spi_m0_edge_counter #(
  parameter int DATA_W = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic step,
  output logic all_sampled
);

  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DATA_W);

  logic [CNT_W-1:0] cnt_q;

  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  function automatic logic reached(input logic [CNT_W-1:0] v);
    return v == LAST_CNT;
  endfunction

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt_q <= '0;
    else if (step)
      cnt_q <= bump(cnt_q);
  end

  assign all_sampled = reached(cnt_q);

  // R5: once the word is complete, no further capture steps occur
  a_r5_no_extra_sample: assert property (@(posedge clk) disable iff (rst)
    (all_sampled && !clear) |-> !step);

endmodule

// File: rtl/spi_m0_shifter.sv
module spi_m0_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_word,
  input  logic              shift_out,
  input  logic              shift_in,
  input  logic              serial_in,
  output logic              serial_out,
  output logic [DATA_W-1:0] word_in
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] tx_sr;
  logic [DATA_W-1:0] rx_sr;

  function automatic logic [DATA_W-1:0] drop_top(input logic [DATA_W-1:0] v);
    return {v[MSB-1:0], 1'b0};
  endfunction

  function automatic logic [DATA_W-1:0] append_bit(input logic [DATA_W-1:0] v,
                                                   input logic b);
    return {v[MSB-1:0], b};
  endfunction

  always_ff @(posedge clk) begin
    if (rst)
      tx_sr <= '0;
    else if (load)
      tx_sr <= load_word;
    else if (shift_out)
      tx_sr <= drop_top(tx_sr);
  end

  always_ff @(posedge clk) begin
    if (rst)
      rx_sr <= '0;
    else if (shift_in)
      rx_sr <= append_bit(rx_sr, serial_in);
  end

  assign serial_out = tx_sr[MSB];
  assign word_in    = rx_sr;

  // R5: each capture step moves the sampled line into the low bit
  a_r5_capture_lsb: assert property (@(posedge clk) disable iff (rst)
    (shift_in && !load) |=> (word_in[0] == $past(serial_in)));

endmodule

// File: rtl/spi_byte_master.sv
module spi_byte_master #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              miso,
  output logic              mosi,
  output logic              sclk,
  output logic              cs_n,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_data
);

  import spi_m0_pkg::*;

  localparam int MSB = DATA_W - 1;

  xfer_state_e state_q;
  logic        done_q;
  logic        running;
  logic        accept;
  logic        last_edge;
  logic        all_sampled;
  logic        rise_evt;
  logic        fall_evt;
  logic        shift_out;
  logic        sclk_int;

  assign running   = (state_q == XS_RUN);
  assign accept    = start && !running;
  assign last_edge = running && sclk_int && all_sampled;
  assign shift_out = fall_evt && !all_sampled;

  spi_m0_sclk_gen u_sclk (
    .clk      (clk),
    .rst      (rst),
    .running  (running),
    .park     (last_edge),
    .sclk     (sclk_int),
    .rise_evt (rise_evt),
    .fall_evt (fall_evt)
  );

  spi_m0_edge_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk         (clk),
    .rst         (rst),
    .clear       (accept),
    .step        (rise_evt),
    .all_sampled (all_sampled)
  );

  spi_m0_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst        (rst),
    .load       (accept),
    .load_word  (tx_data),
    .shift_out  (shift_out),
    .shift_in   (rise_evt),
    .serial_in  (miso),
    .serial_out (mosi),
    .word_in    (rx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= XS_IDLE;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_edge;
      case (state_q)
        XS_IDLE: if (accept)    state_q <= XS_RUN;
        XS_RUN:  if (last_edge) state_q <= XS_IDLE;
        default:                state_q <= XS_IDLE;
      endcase
    end
  end

  assign busy = running;
  assign done = done_q;
  assign cs_n = !running;
  assign sclk = sclk_int;

  // R1: reset forces the idle outputs
  a_r1_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !done && cs_n && !sclk));

  // R2: acceptance selects the slave with the clock low and the top bit out
  a_r2_accept_state: assert property (@(posedge clk) disable iff (rst)
    accept |=> (busy && !cs_n && !sclk && (mosi == $past(tx_data[MSB]))));

  // R4: a rising serial edge leaves the outgoing bit unchanged
  a_r4_mosi_hold_on_rise: assert property (@(posedge clk) disable iff (rst)
    (running && !sclk) |=> $stable(mosi));

  // R6: completion releases the bus and pulses done
  a_r6_finish: assert property (@(posedge clk) disable iff (rst)
    last_edge |=> (done && !busy && cs_n && !sclk));

  // R6: done is a single-cycle pulse
  a_r6_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: a start during a transfer does not end or restart it
  a_r7_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (start && running && !last_edge) |=> busy);

  // R11: idle bus levels
  a_r11_idle_levels: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cs_n && !sclk));

endmodule

// File: tb/spi_byte_master_tb_top.sv
module spi_byte_master_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         miso = 1'b0;
  logic         mosi, sclk, cs_n, busy, done;
  logic [W-1:0] rx_data;

  int n_checks = 0;
  int n_fail   = 0;

  logic [W-1:0] exp_q[$];
  logic [W-1:0] slv_word = '0;
  logic [W-1:0] sent_word = '0;
  int           slv_idx = W - 1;
  bit           finished = 0;

  always #4 clk = ~clk;

  spi_byte_master #(.DATA_W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start), .tx_data(tx_data), .miso(miso),
    .mosi(mosi), .sclk(sclk), .cs_n(cs_n), .busy(busy), .done(done),
    .rx_data(rx_data)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Slave model: during each low phase of sclk, check mosi and present the next miso bit.
  always @(negedge clk) begin
    if (!rst && !cs_n && !sclk && busy && slv_idx >= 0) begin
      check(mosi == sent_word[slv_idx], "R4 mosi bit", 32'(mosi),
            32'(sent_word[slv_idx]));
      miso = slv_word[slv_idx];
      slv_idx--;
    end
  end

  // Monitor: pop the expected word on every done pulse.
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected done", 32'(rx_data), 32'hffff_ffff);
      end else begin
        logic [W-1:0] e;
        e = exp_q.pop_front();
        check(rx_data == e, "R5 rx_data", 32'(rx_data), 32'(e));
      end
    end
  end

  // Call at a negedge: raises start now; returns at the negedge of the done cycle.
  task automatic run_xfer(input logic [W-1:0] tx, input logic [W-1:0] slv,
                          input bit noisy);
    start     = 1'b1;
    tx_data   = tx;
    sent_word = tx;
    slv_word  = slv;
    slv_idx   = W - 1;
    exp_q.push_back(slv);
    @(negedge clk);
    check(busy && !cs_n && !sclk, "R2 accept state",
          {29'd0, busy, cs_n, sclk}, 32'b100);
    check(mosi == tx[W-1], "R2 first bit", 32'(mosi), 32'(tx[W-1]));
    start = 1'b0;
    for (int k = 1; k < 2 * W; k++) begin
      @(negedge clk);
      check(sclk == k[0], "R3 sclk phase", 32'(sclk), 32'(k[0]));
      check(busy, "R7 busy held", 32'(busy), 32'd1);
      if (noisy && k < 2 * W - 1) begin
        start   = 1'b1;
        tx_data = ~tx ^ W'(k);
      end
    end
    start = 1'b0;
    @(negedge clk);
    check(!busy && cs_n && !sclk && done, "R6 finish state",
          {28'd0, busy, cs_n, sclk, done}, 32'b0101);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check(!busy && !done && cs_n && !sclk, "R1 reset idle",
          {28'd0, busy, done, cs_n, sclk}, 32'b0010);
    rst = 1'b0;
    @(negedge clk);
    check(cs_n && !sclk && !done, "R11 idle levels",
          {29'd0, cs_n, sclk, done}, 32'b100);

    run_xfer(8'hA5, 8'h3C, 0);
    @(negedge clk);
    check(!done, "R6 done single cycle", 32'(done), 32'd0);
    check(cs_n && !sclk, "R11 idle after done", {30'd0, cs_n, sclk}, 32'b10);
    run_xfer(8'h00, 8'hFF, 0);
    @(negedge clk);
    run_xfer(8'hFF, 8'h00, 0);
    // R9: back-to-back requests issued in the done cycle
    run_xfer(8'h81, 8'h7E, 0);
    run_xfer(8'h55, 8'hAA, 0);
    @(negedge clk);
    @(negedge clk);
    // R7 / R8: start and tx_data toggled during the transfer
    run_xfer(8'hC3, 8'h96, 1);
    @(negedge clk);
    check(!busy, "R7 no restart", 32'(busy), 32'd0);

    // R10: abort mid-transfer
    start     = 1'b1;
    tx_data   = 8'h5A;
    sent_word = 8'h5A;
    slv_word  = 8'h11;
    slv_idx   = W - 1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(!busy && !done && cs_n && !sclk, "R10 abort idle",
          {28'd0, busy, done, cs_n, sclk}, 32'b0010);
    rst = 1'b0;
    repeat (20) @(negedge clk);
    check(!busy && !done, "R10 no late done", {30'd0, busy, done}, 32'd0);

    run_xfer(8'h69, 8'hE7, 0);
    @(negedge clk);
    check(exp_q.size() == 0, "R6 all words returned", 32'(exp_q.size()), 32'd0);
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        check(1'b0, "watchdog", 32'd0, 32'd1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule